// File: doc/BRIEF.md
# Cascaded Two-Stage PWM Generator

This block produces two pulse-width-modulated outputs from a pair of down-counting channels in one clock domain. The upper channel (channel 1) advances once on every system clock in which the external tick input is high, so it works as a programmable prescaler. The lower channel (channel 0) advances once for every level change of channel 1's internal output, rising or falling. Channel 1's waveform therefore sets the rate of channel 0. Its duty setting also decides whether channel 0 advances at all.

Each channel has a period value, a high-time value, an enable and an invert control, all taken directly from input ports. On enable the channel loads its period value and counts down to 1, then reloads. Its internal output is high while the count is at or below the high-time value. The pin carries that level, or its inverse when the invert control is set. For evenly spaced steps on channel 0, channel 1 should run at 50% duty. Each channel 0 output period then equals its period value times channel 1's high time.

Top module: `ppgCascade`

## Requirements
- R1: On the clock edge where a channel's enable is first seen high, the counter loads the period value. After that it steps down by one on each count event. An event at count 1 (or 0) reloads the period value, so the output period is the period value times the spacing of count events.
- R2: The internal output is high exactly while the count is at or below the high-time value. With period 4 and high time 2 and a tick on every clock, the pin reads 0,0,1,1 after the load edge and the three following edges, and then repeats.
- R3: A high-time value of 0 holds the internal output low. A high-time value equal to or above the period value holds it high.
- R4: A pin equals its channel's internal output when its invert input is 0, and the inverse of it when the invert input is 1. The invert input acts without delay.
- R5: While a channel is disabled, and after reset, its internal output is low and its counter does not change.
- R6: Channel 0 receives a count event of one clock for each rising and each falling edge of channel 1's internal output. Channel 1's invert input and pin create no count events.
- R7: While channel 1 is disabled, channel 0 does not count, even when channel 0 is enabled.
- R8: While channel 1's output stays constant (high time 0, or high time at or above the period), channel 0 keeps its count and output level.
- R9: The period and high-time inputs are captured only at a load or a reload. A change made during a period takes effect at the next period boundary.
- R10: Channel 1 counts only on clocks where the tick input is high. With a tick on every third clock, a period of 4 and a high time of 2 give a 12-clock period with 6 clocks high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| tickIn | input | 1 | Count enable for channel 1, one clock per event |
| ch1Enable | input | 1 | Channel 1 run enable |
| ch1Invert | input | 1 | Channel 1 pin polarity invert |
| ch1Period | input | 8 | Channel 1 period value in count events |
| ch1High | input | 8 | Channel 1 high time in count events |
| ch0Enable | input | 1 | Channel 0 run enable |
| ch0Invert | input | 1 | Channel 0 pin polarity invert |
| ch0Period | input | 8 | Channel 0 period value in count events |
| ch0High | input | 8 | Channel 0 high time in count events |
| ch1Pin | output | 1 | Channel 1 PWM output |
| ch0Pin | output | 1 | Channel 0 PWM output |

## Verification
The bound checker watches several rules on every clock. Channel 1 steps down by exactly one per tick and holds between ticks. A disabled channel drops its internal output. Channel 0's counter stays frozen while channel 1 is off. Every channel 0 count event lines up with a level change of channel 1's output. Other properties show only across whole waveforms, so the bench's scenarios cover them: exact pin traces, the high-time and period ratios of the cascade, the 0% and 100% cases, invert behaviour, and the deferred capture of new settings at a period boundary.

// File: rtl/ppgCascadePkg.sv
package ppgCascadePkg;

  // Per-channel command strobes issued by the control to the datapath.
  typedef struct packed {
    logic clear;   // channel disabled: force internal output low, freeze count
    logic load;    // first enabled clock: capture settings, start counting
    logic reload;  // count event at end of period: capture settings again
    logic step;    // count event mid-period: decrement
  } chStrobeT;

endpackage

// File: rtl/ppgControl.sv
module ppgControl
  import ppgCascadePkg::*;
#(
  parameter int NCH = 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     extTick,
  input  logic [NCH-1:0]           enable,
  input  logic [NCH-1:0]           rawLevel,
  input  logic [NCH-1:0]           atEnd,
  output chStrobeT [NCH-1:0]       strobe,
  output logic [NCH-1:0]           chTick
);

  logic [NCH-1:0] running;
  logic [NCH-1:0] rawDly;

  // Registered copies: run state and previous internal output level.
  always_ff @(posedge clk) begin
    if (rst) begin
      running <= '0;
      rawDly  <= '0;
    end else begin
      running <= enable;
      rawDly  <= rawLevel;
    end
  end

  // Count-event chain: the top channel uses the external tick; each lower
  // channel uses both edges of the next higher channel's internal output,
  // gated by that channel's enable.
  genvar gi;
  generate
    for (gi = 0; gi < NCH; gi++) begin : g_tick
      if (gi == NCH - 1) begin : g_top
        assign chTick[gi] = extTick;
      end else begin : g_chain
        assign chTick[gi] = enable[gi+1] & (rawLevel[gi+1] ^ rawDly[gi+1]);
      end
    end
  endgenerate

  generate
    for (gi = 0; gi < NCH; gi++) begin : g_strobe
      always_comb begin
        strobe[gi].clear  = ~enable[gi];
        strobe[gi].load   = enable[gi] & ~running[gi];
        strobe[gi].reload = enable[gi] & running[gi] & chTick[gi] & atEnd[gi];
        strobe[gi].step   = enable[gi] & running[gi] & chTick[gi] & ~atEnd[gi];
      end
    end
  endgenerate

endmodule

// File: rtl/ppgDatapath.sv
module ppgDatapath
  import ppgCascadePkg::*;
#(
  parameter int W   = 8,
  parameter int NCH = 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  chStrobeT [NCH-1:0]       strobe,
  input  logic [NCH-1:0][W-1:0]    periodIn,
  input  logic [NCH-1:0][W-1:0]    highIn,
  input  logic [NCH-1:0]           invertIn,
  output logic [NCH-1:0][W-1:0]    count,
  output logic [NCH-1:0]           rawLevel,
  output logic [NCH-1:0]           atEnd,
  output logic [NCH-1:0]           pinOut
);

  localparam logic [W-1:0] ONE = W'(1);

  logic [NCH-1:0][W-1:0] highWork;
  logic [NCH-1:0][W-1:0] countDec;

  genvar gi;
  generate
    for (gi = 0; gi < NCH; gi++) begin : g_ch
      assign countDec[gi] = count[gi] - ONE;
      assign atEnd[gi]    = (count[gi] <= ONE);
      assign pinOut[gi]   = rawLevel[gi] ^ invertIn[gi];

      always_ff @(posedge clk) begin
        if (rst) begin
          count[gi]    <= '0;
          highWork[gi] <= '0;
          rawLevel[gi] <= 1'b0;
        end else if (strobe[gi].clear) begin
          rawLevel[gi] <= 1'b0;
        end else if (strobe[gi].load || strobe[gi].reload) begin
          count[gi]    <= periodIn[gi];
          highWork[gi] <= highIn[gi];
          rawLevel[gi] <= (highIn[gi] != '0) && (periodIn[gi] <= highIn[gi]);
        end else if (strobe[gi].step) begin
          count[gi]    <= countDec[gi];
          rawLevel[gi] <= (highWork[gi] != '0) && (countDec[gi] <= highWork[gi]);
        end
      end
    end
  endgenerate

endmodule

// File: rtl/ppgCascade.sv
module ppgCascade
  import ppgCascadePkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tickIn,
  input  logic         ch1Enable,
  input  logic         ch1Invert,
  input  logic [W-1:0] ch1Period,
  input  logic [W-1:0] ch1High,
  input  logic         ch0Enable,
  input  logic         ch0Invert,
  input  logic [W-1:0] ch0Period,
  input  logic [W-1:0] ch0High,
  output logic         ch1Pin,
  output logic         ch0Pin
);

  localparam int NCH = 2;

  chStrobeT [NCH-1:0]    strobe;
  logic [NCH-1:0]        enable;
  logic [NCH-1:0]        invert;
  logic [NCH-1:0][W-1:0] period;
  logic [NCH-1:0][W-1:0] high;
  logic [NCH-1:0][W-1:0] count;
  logic [NCH-1:0]        rawLevel;
  logic [NCH-1:0]        atEnd;
  logic [NCH-1:0]        pinOut;
  logic [NCH-1:0]        chTick;

  assign enable = {ch1Enable, ch0Enable};
  assign invert = {ch1Invert, ch0Invert};
  assign period = {ch1Period, ch0Period};
  assign high   = {ch1High, ch0High};
  assign ch1Pin = pinOut[1];
  assign ch0Pin = pinOut[0];

  ppgControl #(.NCH(NCH)) ctrl (
    .clk(clk), .rst(rst), .extTick(tickIn), .enable(enable),
    .rawLevel(rawLevel), .atEnd(atEnd), .strobe(strobe), .chTick(chTick)
  );

  ppgDatapath #(.W(W), .NCH(NCH)) dp (
    .clk(clk), .rst(rst), .strobe(strobe), .periodIn(period), .highIn(high),
    .invertIn(invert), .count(count), .rawLevel(rawLevel), .atEnd(atEnd),
    .pinOut(pinOut)
  );

endmodule

// File: rtl/ppgCascadeChecker.sv
module ppgCascadeChecker #(
  parameter int W = 8
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  tickIn,
  input logic [1:0]            enable,
  input logic [1:0][W-1:0]     count,
  input logic [1:0]            rawLevel,
  input logic [1:0]            chTick
);

  // R1: channel 1 steps down by one per tick mid-period
  p_count_step_r1: assert property (@(posedge clk) disable iff (rst)
    (enable[1] && $past(enable[1]) && tickIn && count[1] > W'(1))
      |=> (count[1] == $past(count[1]) - W'(1)));

  // R10: without a tick a running channel 1 holds its count
  p_idle_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (enable[1] && $past(enable[1]) && !tickIn) |=> $stable(count[1]));

  // R5: a disabled channel drives its internal output low
  p_disabled_low_r5: assert property (@(posedge clk) disable iff (rst)
    (!enable[0]) |=> !rawLevel[0]);

  p_disabled_low1_r5: assert property (@(posedge clk) disable iff (rst)
    (!enable[1]) |=> !rawLevel[1]);

  // R7: channel 0 keeps its count while channel 1 is off (except its own load)
  p_ch0_frozen_r7: assert property (@(posedge clk) disable iff (rst)
    (!enable[1] && (!enable[0] || $past(enable[0]))) |=> $stable(count[0]));

  // R6: every channel 0 count event coincides with a channel 1 level change
  p_tick_edge_r6: assert property (@(posedge clk) disable iff (rst)
    chTick[0] |-> (rawLevel[1] != $past(rawLevel[1])));

endmodule

bind ppgCascade ppgCascadeChecker #(.W(W)) chk (
  .clk(clk), .rst(rst), .tickIn(tickIn), .enable(enable),
  .count(count), .rawLevel(rawLevel), .chTick(chTick)
);

// File: tb/ppgCascade_test.sv
`timescale 1ns/1ps
module ppgCascade_test;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tickIn = 1'b0;
  logic       ch1Enable = 1'b0, ch1Invert = 1'b0;
  logic [7:0] ch1Period = 8'd0, ch1High = 8'd0;
  logic       ch0Enable = 1'b0, ch0Invert = 1'b0;
  logic [7:0] ch0Period = 8'd0, ch0High = 8'd0;
  logic       ch1Pin, ch0Pin;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  ppgCascade uut (
    .clk(clk), .rst(rst), .tickIn(tickIn),
    .ch1Enable(ch1Enable), .ch1Invert(ch1Invert), .ch1Period(ch1Period), .ch1High(ch1High),
    .ch0Enable(ch0Enable), .ch0Invert(ch0Invert), .ch0Period(ch0Period), .ch0High(ch0High),
    .ch1Pin(ch1Pin), .ch0Pin(ch0Pin)
  );

  task automatic check(input string req, input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Runs n clocks; tick high on every div-th clock. Samples pins at negedges.
  task automatic runWindow(input int n, input int div,
                           output int hi0, output int hi1,
                           output int rise0, output int rise1);
    logic p0, p1;
    int phase = 0;
    hi0 = 0; hi1 = 0; rise0 = 0; rise1 = 0;
    p0 = ch0Pin; p1 = ch1Pin;
    for (int k = 0; k < n; k++) begin
      tickIn = (phase == div - 1);
      phase = (phase == div - 1) ? 0 : phase + 1;
      @(negedge clk);
      if (ch0Pin) hi0++;
      if (ch1Pin) hi1++;
      if (ch0Pin && !p0) rise0++;
      if (ch1Pin && !p1) rise1++;
      p0 = ch0Pin; p1 = ch1Pin;
    end
  endtask

  task automatic quiesce();
    ch0Enable = 0; ch1Enable = 0; ch0Invert = 0; ch1Invert = 0; tickIn = 1;
    repeat (3) @(negedge clk);
  endtask

  task automatic testReset();
    rst = 1;
    repeat (4) @(negedge clk);
    check("R5", ch1Pin, 0, "ch1 pin in reset");
    check("R5", ch0Pin, 0, "ch0 pin in reset");
    rst = 0;
    @(negedge clk);
    check("R5", ch0Pin, 0, "ch0 pin after reset");
  endtask

  task automatic testTrace();
    logic [8:0] exp = 9'b011001100; // bit k = sample after edge k (LSB first)
    quiesce();
    ch1Period = 4; ch1High = 2; tickIn = 1;
    ch1Enable = 1;
    for (int k = 0; k < 9; k++) begin
      @(negedge clk);
      check("R2", ch1Pin, exp[k], $sformatf("ch1 trace sample %0d", k));
    end
  endtask

  task automatic testDeferredHigh();
    logic [8:0] exp = 9'b011101100;
    quiesce();
    ch1Period = 4; ch1High = 2; tickIn = 1;
    ch1Enable = 1;
    for (int k = 0; k < 9; k++) begin
      @(negedge clk);
      if (k == 0) ch1High = 3; // change mid-period
      check("R9", ch1Pin, exp[k], $sformatf("deferred high sample %0d", k));
    end
    ch1High = 2;
  endtask

  task automatic testCascade();
    int h0, h1, r0, r1;
    quiesce();
    ch1Period = 4; ch1High = 2; ch0Period = 3; ch0High = 1;
    ch1Enable = 1; ch0Enable = 1;
    runWindow(20, 1, h0, h1, r0, r1);
    runWindow(48, 1, h0, h1, r0, r1);
    check("R1", r1, 12, "ch1 periods in 48 clocks");
    check("R2", h1, 24, "ch1 high clocks in 48");
    check("R6", r0, 8, "ch0 periods in 48 clocks");
    check("R6", h0, 16, "ch0 high clocks in 48");
  endtask

  task automatic testTickDivide();
    int h0, h1, r0, r1;
    quiesce();
    ch1Period = 4; ch1High = 2;
    ch1Enable = 1;
    runWindow(24, 3, h0, h1, r0, r1);
    runWindow(48, 3, h0, h1, r0, r1);
    check("R10", r1, 4, "ch1 periods with tick every 3rd clock");
    check("R10", h1, 24, "ch1 high clocks with tick every 3rd clock");
  endtask

  task automatic testCh1Off();
    int h0, h1, r0, r1;
    quiesce();
    ch0Period = 3; ch0High = 1;
    ch0Enable = 1;
    runWindow(40, 1, h0, h1, r0, r1);
    check("R7", h0, 0, "ch0 high clocks with ch1 disabled");
    // start ch1 later: ch0 must still begin from its loaded count (3):
    // first ch0 rise needs two ch1 edges -> ch1 edges after 2 and 4 clocks
    ch1Period = 4; ch1High = 2; ch1Enable = 1;
    runWindow(5, 1, h0, h1, r0, r1);
    check("R7", r0, 0, "no ch0 rise before second ch1 edge");
    runWindow(2, 1, h0, h1, r0, r1);
    check("R7", r0, 1, "ch0 rises after second ch1 edge");
  endtask

  task automatic testSteadyCh1();
    int h0, h1, r0, r1;
    quiesce();
    ch1Period = 4; ch1High = 0; ch0Period = 3; ch0High = 1;
    ch1Enable = 1; ch0Enable = 1;
    for (int k = 0; k < 12; k++) begin
      ch1Invert = k[0];
      @(negedge clk);
      if (k > 1) check("R4", ch1Pin, k[0], "ch1 pin follows invert at 0% duty");
      check("R8", ch0Pin, 0, "ch0 idle while ch1 at 0% and ch1 invert toggles");
    end
    quiesce();
    ch1Period = 4; ch1High = 5;
    ch1Enable = 1; ch0Enable = 1;
    runWindow(30, 1, h0, h1, r0, r1);
    check("R3", h1, 30, "ch1 always high when high time >= period");
    check("R8", h0, 0, "ch0 low while ch1 output constant");
  endtask

  task automatic testCh0DutyLimits();
    int h0, h1, r0, r1;
    quiesce();
    ch1Period = 2; ch1High = 1; ch0Period = 3; ch0High = 0;
    ch1Enable = 1; ch0Enable = 1;
    runWindow(30, 1, h0, h1, r0, r1);
    check("R3", h0, 0, "ch0 low with high time 0");
    check("R1", r1, 15, "ch1 periods at period 2");
  endtask

  task automatic testDisableAndInvert();
    int h0, h1, r0, r1;
    quiesce();
    ch1Period = 4; ch1High = 2; ch0Period = 3; ch0High = 1;
    ch1Enable = 1; ch0Enable = 1;
    runWindow(20, 1, h0, h1, r0, r1);
    ch0Enable = 0;
    runWindow(30, 1, h0, h1, r0, r1);
    check("R5", h0, 0, "disabled ch0 stays low while ch1 runs");
    ch0Invert = 1;
    #0.1;
    check("R4", ch0Pin, 1, "inverted pin of disabled ch0");
    // stop ch1 while ch0 runs: ch0 pin must hold its level
    ch0Invert = 0; ch0Enable = 1;
    runWindow(20, 1, h0, h1, r0, r1);
    ch1Enable = 0;
    runWindow(2, 1, h0, h1, r0, r1);
    begin
      logic held = ch0Pin;
      runWindow(30, 1, h0, h1, r0, r1);
      check("R7", h0, held ? 30 : 0, "ch0 pin holds with ch1 stopped");
    end
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    testReset();
    testTrace();
    testDeferredHigh();
    testCascade();
    testTickDivide();
    testCh1Off();
    testSteadyCh1();
    testCh0DutyLimits();
    testDisableAndInvert();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule